// File: doc/BRIEF.md
# Page-Table Entry Refill Walker

This block services a translation-buffer miss by fetching the matching page-table entry from memory and turning it into a refill write for one of four refill ways. A miss request carries the missing virtual address, the ring level of the access and the cause code the miss would raise. From the page-table base register and the missing address, the walker forms the virtual address of the page-table entry. It asks an external translator to map that address in one cycle, then reads the 32-bit entry through a valid/ready read port. After that it emits one install strobe with the way, virtual page, physical page, ASID and attribute fields.

The block also holds the page-table base register. A write to it keeps only the top ten bits. A read of it returns the base combined with the shifted fault address, so software can see the entry address that belongs to the last fault. A miss taken at ring 0 whose address falls inside the 4 MB window covered by the base is not walked, because that would be a walk of the page table itself. The block also gives up when the translator cannot map the entry address. In both cases it reports failure with the cause it was given, unchanged.

Top module: `pte_refill_walker`

## Requirements
- R1: After reset the base register reads as zero. A write stores the written value with bits [21:0] forced to zero.
- R2: The base readback output is (base | (fault_vaddr >> 10)) with bits [1:0] forced to zero. It follows both inputs at once.
- R3: For a walked miss, the translator request address is (base | (miss address >> 10)) with bits [1:0] cleared. The memory read address is the translator's returned physical address.
- R4: A ring-0 miss is not walked when its address bits [31:22] equal base bits [31:22]. In that case there is no translator request, no memory request and no install, and the done pulse reports failure with the original cause.
- R5: When the translator answers not-ok, there is no memory request and no install, and the done pulse reports failure with the original cause.
- R6: The refill way is the low 2 bits of a counter after it is incremented. The counter resets to 0, so the first install goes to way 1 and later ones to 2, 3, 0, 1 and so on. Only a successful install advances the counter.
- R7: The installed ring is PTE bits [5:4]. The installed ASID is byte number "ring" of the ring-ASID input, where byte 0 is bits [7:0].
- R8: The installed physical page is the PTE with bits [11:0] cleared. The attribute is PTE bits [3:0]. The virtual page is the miss address with bits [11:0] cleared. A success done pulse with cause 0 comes in the same cycle as the install strobe.
- R9: Busy is high from the cycle after a miss is accepted until the walk ends. A miss presented while busy is ignored.
- R10: The memory request holds its valid and address until ready is seen. The walker then waits any number of cycles for the single-cycle response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_wr_en | input | 1 | Write strobe for the page-table base register |
| base_wr_data | input | 32 | Value to write to the base register |
| fault_vaddr | input | 32 | Last faulting virtual address, used for readback |
| base_rd_data | output | 32 | Base register readback |
| ring_asid | input | 32 | Four ASID bytes, one per ring |
| miss_valid | input | 1 | Miss request, taken when busy is low |
| miss_vaddr | input | 32 | Missing virtual address |
| miss_ring | input | 2 | Ring level of the missing access |
| miss_cause | input | 6 | Cause code of the miss |
| busy | output | 1 | Walk in progress |
| xl_req | output | 1 | Translate request for the entry address |
| xl_vaddr | output | 32 | Entry virtual address to translate |
| xl_ok | input | 1 | Translation succeeded (same cycle) |
| xl_paddr | input | 32 | Translated entry physical address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Memory read address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid, one cycle |
| mem_rsp_data | input | 32 | Page-table entry read |
| inst_valid | output | 1 | Install strobe for the refill way |
| inst_way | output | 2 | Refill way to write |
| inst_vpn | output | 32 | Virtual page of the new entry |
| inst_ppn | output | 32 | Physical page of the new entry |
| inst_asid | output | 8 | ASID of the new entry |
| inst_ring | output | 2 | Ring of the new entry |
| inst_attr | output | 4 | Attribute of the new entry |
| done_valid | output | 1 | Walk finished, one cycle |
| done_ok | output | 1 | Walk installed an entry |
| done_cause | output | 6 | Original cause on failure, zero on success |

## Verification
The bench builds the walker with its default parameters: 32-bit addresses, four refill ways, four rings of 8-bit ASIDs and 4 KB refill pages. With these values the whole ring space and a full wrap of the round-robin way counter fit in a short run. It sweeps several base values against addresses inside and outside each base's window at every ring. This covers the ring-0 self-walk skip, the translator refusal, memory stalls, and misses presented while busy. Every walk's translator address, memory address and installed fields are recomputed arithmetically from the base and the miss address.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    WS_IDLE    = 3'd0,
    WS_XLATE   = 3'd1,
    WS_READ    = 3'd2,
    WS_WAIT    = 3'd3,
    WS_INSTALL = 3'd4
  } walk_state_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 22,
  parameter int PTE_SHIFT  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] fault_vaddr,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] rd_data
);
  localparam logic [ADDR_W-1:0] KEEP_MASK  = {ADDR_W{1'b1}} << REGION_LSB;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << 2;

  logic [ADDR_W-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (wr_en) base_d = wr_data & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= '0;
    else        base_q <= base_d;
  end

  assign rd_data = (base_q | (fault_vaddr >> PTE_SHIFT)) & ALIGN_MASK;

  // R1
  base_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> base_q == ($past(wr_data) & KEEP_MASK));
endmodule

// File: rtl/ptw_pte_fields.sv
module ptw_pte_fields #(
  parameter int ADDR_W   = 32,
  parameter int PAGE_LSB = 12,
  parameter int RING_W   = 2,
  parameter int RING_LSB = 4,
  parameter int ASID_W   = 8,
  parameter int ATTR_W   = 4
) (
  input  logic [ADDR_W-1:0]                 vaddr,
  input  logic [ADDR_W-1:0]                 pte,
  input  logic [(2**RING_W)*ASID_W-1:0]     ring_asid,
  output logic [ADDR_W-1:0]                 vpn,
  output logic [ADDR_W-1:0]                 ppn,
  output logic [ASID_W-1:0]                 asid,
  output logic [RING_W-1:0]                 ring,
  output logic [ATTR_W-1:0]                 attr
);
  localparam int NUM_RINGS = 2 ** RING_W;
  localparam logic [ADDR_W-1:0] PAGE_MASK = {ADDR_W{1'b1}} << PAGE_LSB;

  logic [ASID_W-1:0] asid_byte [NUM_RINGS];

  for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
    assign asid_byte[g] = ring_asid[g*ASID_W +: ASID_W];
  end

  assign ring = pte[RING_LSB +: RING_W];
  assign asid = asid_byte[ring];
  assign attr = pte[ATTR_W-1:0];
  assign ppn  = pte & PAGE_MASK;
  assign vpn  = vaddr & PAGE_MASK;
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 22,
  parameter int PTE_SHIFT  = 10,
  parameter int RING_W     = 2,
  parameter int CAUSE_W    = 6,
  parameter int NUM_WAYS   = 4,
  parameter int CNT_W      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               miss_valid,
  input  logic [ADDR_W-1:0]  miss_vaddr,
  input  logic [RING_W-1:0]  miss_ring,
  input  logic [CAUSE_W-1:0] miss_cause,
  input  logic [ADDR_W-1:0]  base_q,
  output logic               busy,
  output logic               xl_req,
  output logic [ADDR_W-1:0]  xl_vaddr,
  input  logic               xl_ok,
  input  logic [ADDR_W-1:0]  xl_paddr,
  output logic               mem_req_valid,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic [ADDR_W-1:0]  mem_rsp_data,
  output logic [ADDR_W-1:0]  vaddr_q,
  output logic [ADDR_W-1:0]  pte_q,
  output logic               inst_valid,
  output logic [$clog2(NUM_WAYS)-1:0] inst_way,
  output logic               done_valid,
  output logic               done_ok,
  output logic [CAUSE_W-1:0] done_cause
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << 2;

  walk_state_e        state_q, state_d;
  logic               load_en, paddr_en, pte_en, cnt_en;
  logic               skip_q, skip_d;
  logic [CAUSE_W-1:0] cause_q;
  logic [ADDR_W-1:0]  paddr_q;
  logic [CNT_W-1:0]   cnt_q, cnt_inc;

  assign skip_d  = (miss_ring == '0) &&
                   (miss_vaddr[ADDR_W-1:REGION_LSB] == base_q[ADDR_W-1:REGION_LSB]);
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    paddr_en = 1'b0;
    pte_en   = 1'b0;
    cnt_en   = 1'b0;
    case (state_q)
      WS_IDLE: if (miss_valid) begin
        load_en = 1'b1;
        state_d = WS_XLATE;
      end
      WS_XLATE: if (skip_q || !xl_ok) begin
        state_d = WS_IDLE;
      end else begin
        paddr_en = 1'b1;
        state_d  = WS_READ;
      end
      WS_READ: if (mem_req_ready) state_d = WS_WAIT;
      WS_WAIT: if (mem_rsp_valid) begin
        pte_en  = 1'b1;
        state_d = WS_INSTALL;
      end
      WS_INSTALL: begin
        cnt_en  = 1'b1;
        state_d = WS_IDLE;
      end
      default: state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      vaddr_q <= '0;
      cause_q <= '0;
      skip_q  <= 1'b0;
      paddr_q <= '0;
      pte_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_en) begin
        vaddr_q <= miss_vaddr;
        cause_q <= miss_cause;
        skip_q  <= skip_d;
      end
      if (paddr_en) paddr_q <= xl_paddr;
      if (pte_en)   pte_q   <= mem_rsp_data;
      if (cnt_en)   cnt_q   <= cnt_inc;
    end
  end

  assign busy          = (state_q != WS_IDLE);
  assign xl_req        = (state_q == WS_XLATE) && !skip_q;
  assign xl_vaddr      = (base_q | (vaddr_q >> PTE_SHIFT)) & ALIGN_MASK;
  assign mem_req_valid = (state_q == WS_READ);
  assign mem_req_addr  = paddr_q;
  assign inst_valid    = (state_q == WS_INSTALL);
  assign inst_way      = cnt_inc[WAY_W-1:0];
  assign done_ok       = (state_q == WS_INSTALL);
  assign done_valid    = done_ok || ((state_q == WS_XLATE) && (skip_q || !xl_ok));
  assign done_cause    = done_ok ? '0 : cause_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  // R6
  way_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inst_valid |=> $stable(cnt_q));
  // R5
  fail_no_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && !done_ok |-> !inst_valid && !mem_req_valid);
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && miss_valid |=> $stable(vaddr_q));
endmodule

// File: rtl/pte_refill_walker.sv
module pte_refill_walker #(
  parameter int ADDR_W     = 32,
  parameter int REGION_LSB = 22,
  parameter int PTE_SHIFT  = 10,
  parameter int PAGE_LSB   = 12,
  parameter int RING_W     = 2,
  parameter int RING_LSB   = 4,
  parameter int ASID_W     = 8,
  parameter int ATTR_W     = 4,
  parameter int CAUSE_W    = 6,
  parameter int NUM_WAYS   = 4,
  parameter int CNT_W      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          base_wr_en,
  input  logic [ADDR_W-1:0]             base_wr_data,
  input  logic [ADDR_W-1:0]             fault_vaddr,
  output logic [ADDR_W-1:0]             base_rd_data,
  input  logic [(2**RING_W)*ASID_W-1:0] ring_asid,
  input  logic                          miss_valid,
  input  logic [ADDR_W-1:0]             miss_vaddr,
  input  logic [RING_W-1:0]             miss_ring,
  input  logic [CAUSE_W-1:0]            miss_cause,
  output logic                          busy,
  output logic                          xl_req,
  output logic [ADDR_W-1:0]             xl_vaddr,
  input  logic                          xl_ok,
  input  logic [ADDR_W-1:0]             xl_paddr,
  output logic                          mem_req_valid,
  output logic [ADDR_W-1:0]             mem_req_addr,
  input  logic                          mem_req_ready,
  input  logic                          mem_rsp_valid,
  input  logic [ADDR_W-1:0]             mem_rsp_data,
  output logic                          inst_valid,
  output logic [$clog2(NUM_WAYS)-1:0]   inst_way,
  output logic [ADDR_W-1:0]             inst_vpn,
  output logic [ADDR_W-1:0]             inst_ppn,
  output logic [ASID_W-1:0]             inst_asid,
  output logic [RING_W-1:0]             inst_ring,
  output logic [ATTR_W-1:0]             inst_attr,
  output logic                          done_valid,
  output logic                          done_ok,
  output logic [CAUSE_W-1:0]            done_cause
);
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] vaddr_q;
  logic [ADDR_W-1:0] pte_q;

  ptw_base_reg #(
    .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .PTE_SHIFT(PTE_SHIFT)
  ) u_base (
    .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en), .wr_data(base_wr_data),
    .fault_vaddr(fault_vaddr), .base_q(base_q), .rd_data(base_rd_data)
  );

  ptw_ctrl #(
    .ADDR_W(ADDR_W), .REGION_LSB(REGION_LSB), .PTE_SHIFT(PTE_SHIFT),
    .RING_W(RING_W), .CAUSE_W(CAUSE_W), .NUM_WAYS(NUM_WAYS), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_ring(miss_ring),
    .miss_cause(miss_cause), .base_q(base_q), .busy(busy),
    .xl_req(xl_req), .xl_vaddr(xl_vaddr), .xl_ok(xl_ok), .xl_paddr(xl_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .vaddr_q(vaddr_q), .pte_q(pte_q),
    .inst_valid(inst_valid), .inst_way(inst_way),
    .done_valid(done_valid), .done_ok(done_ok), .done_cause(done_cause)
  );

  ptw_pte_fields #(
    .ADDR_W(ADDR_W), .PAGE_LSB(PAGE_LSB), .RING_W(RING_W),
    .RING_LSB(RING_LSB), .ASID_W(ASID_W), .ATTR_W(ATTR_W)
  ) u_fields (
    .vaddr(vaddr_q), .pte(pte_q), .ring_asid(ring_asid),
    .vpn(inst_vpn), .ppn(inst_ppn), .asid(inst_asid),
    .ring(inst_ring), .attr(inst_attr)
  );

  // R4
  self_walk_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && ($past(miss_ring) == '0) &&
    ($past(miss_vaddr[ADDR_W-1:REGION_LSB]) == base_q[ADDR_W-1:REGION_LSB])
    |-> !xl_req && done_valid && !done_ok);
  // R3
  xl_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |-> xl_vaddr[1:0] == 2'b00);
endmodule

// File: tb/pte_refill_walker_bench.sv
module pte_refill_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_wr_en = 1'b0;
  logic [31:0] base_wr_data = '0;
  logic [31:0] fault_vaddr = '0;
  logic [31:0] base_rd_data;
  logic [31:0] ring_asid = 32'h4B3A2901;
  logic        miss_valid = 1'b0;
  logic [31:0] miss_vaddr = '0;
  logic [1:0]  miss_ring = '0;
  logic [5:0]  miss_cause = '0;
  logic        busy, xl_req, xl_ok;
  logic [31:0] xl_vaddr, xl_paddr;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        inst_valid;
  logic [1:0]  inst_way;
  logic [31:0] inst_vpn, inst_ppn;
  logic [7:0]  inst_asid;
  logic [1:0]  inst_ring;
  logic [3:0]  inst_attr;
  logic        done_valid, done_ok;
  logic [5:0]  done_cause;

  int n_checks = 0;
  int n_fail = 0;
  logic xl_fail = 1'b0;
  int stall_left = 0;

  always #10 clk = ~clk;

  pte_refill_walker u_pte_refill_walker (
    .clk(clk), .rst_n(rst_n), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .fault_vaddr(fault_vaddr), .base_rd_data(base_rd_data), .ring_asid(ring_asid),
    .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_ring(miss_ring),
    .miss_cause(miss_cause), .busy(busy), .xl_req(xl_req), .xl_vaddr(xl_vaddr),
    .xl_ok(xl_ok), .xl_paddr(xl_paddr), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .inst_valid(inst_valid), .inst_way(inst_way), .inst_vpn(inst_vpn),
    .inst_ppn(inst_ppn), .inst_asid(inst_asid), .inst_ring(inst_ring),
    .inst_attr(inst_attr), .done_valid(done_valid), .done_ok(done_ok),
    .done_cause(done_cause)
  );

  function automatic logic [31:0] pte_of(logic [31:0] a);
    return {a[31:12] ^ 20'hA5C3F, 6'b101010, a[3:2], a[5:2]};
  endfunction

  assign xl_ok    = !xl_fail;
  assign xl_paddr = {4'h3, xl_vaddr[27:0]};

  logic        hs_q = 1'b0;
  logic [31:0] hs_addr = '0;
  int          n_mem_req = 0;
  int          n_xl_req = 0;
  int          n_inst = 0;
  int          n_done = 0;
  logic        got_ok;
  logic [5:0]  got_cause;
  logic [1:0]  got_way;
  logic [31:0] got_vpn, got_ppn, got_xl;
  logic [7:0]  got_asid;
  logic [1:0]  got_ring;
  logic [3:0]  got_attr;

  always @(posedge clk) begin
    hs_q <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      hs_addr   <= mem_req_addr;
      n_mem_req <= n_mem_req + 1;
    end
    if (xl_req) n_xl_req <= n_xl_req + 1;
  end

  always @(negedge clk) begin
    if (hs_q) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pte_of(hs_addr);
    end else begin
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = 32'hDEAD_BEEF;
    end
    mem_req_ready = (stall_left == 0);
    if (mem_req_valid && stall_left != 0) stall_left = stall_left - 1;
    if (xl_req) got_xl = xl_vaddr;
    if (inst_valid) begin
      n_inst++;
      got_way = inst_way; got_vpn = inst_vpn; got_ppn = inst_ppn;
      got_asid = inst_asid; got_ring = inst_ring; got_attr = inst_attr;
    end
    if (done_valid) begin
      n_done++;
      got_ok = done_ok; got_cause = done_cause;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] base_model = '0;
  int          exp_cnt = 0;

  task automatic write_base(logic [31:0] v);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = v;
    @(negedge clk);
    base_wr_en = 1'b0;
    base_model = v & 32'hFFC0_0000;
  endtask

  task automatic do_miss(logic [31:0] v, logic [1:0] r, logic [5:0] c, int stall,
                         logic inject_busy);
    int done0 = n_done;
    int mem0 = n_mem_req;
    int xl0 = n_xl_req;
    int inst0 = n_inst;
    logic skip;
    logic [31:0] pa, ma, pte;
    @(negedge clk);
    stall_left = stall;
    miss_valid = 1'b1; miss_vaddr = v; miss_ring = r; miss_cause = c;
    @(negedge clk);
    miss_valid = 1'b0;
    check("R9 busy after accept", {31'b0, busy}, 32'd1);
    if (inject_busy) begin
      miss_valid = 1'b1; miss_vaddr = v ^ 32'h0055_5000; miss_ring = r ^ 2'd1;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    for (int i = 0; i < 40 && n_done == done0; i++) @(negedge clk);
    @(negedge clk);
    skip = (r == 2'd0) && (v[31:22] == base_model[31:22]);
    pa = (base_model | (v >> 10)) & 32'hFFFF_FFFC;
    ma = {4'h3, pa[27:0]};
    pte = pte_of(ma);
    check("R9 one done per miss", n_done - done0, 1);
    check("R9 idle after walk", {31'b0, busy}, 32'd0);
    if (skip) begin
      check("R4 no xlate", n_xl_req - xl0, 0);
      check("R4 no mem", n_mem_req - mem0, 0);
      check("R4 fail", {31'b0, got_ok}, 0);
      check("R4 cause", {26'b0, got_cause}, {26'b0, c});
    end else if (xl_fail) begin
      check("R5 xlate seen", n_xl_req - xl0, 1);
      check("R5 no mem", n_mem_req - mem0, 0);
      check("R5 no install", n_inst - inst0, 0);
      check("R5 fail", {31'b0, got_ok}, 0);
      check("R5 cause", {26'b0, got_cause}, {26'b0, c});
    end else begin
      exp_cnt++;
      check("R3 xlate addr", got_xl, pa);
      check("R3 mem addr", hs_addr, ma);
      check("R10 one mem req", n_mem_req - mem0, 1);
      check("R8 ok", {31'b0, got_ok}, 1);
      check("R8 cause zero", {26'b0, got_cause}, 0);
      check("R6 way", {30'b0, got_way}, exp_cnt % 4);
      check("R7 ring", {30'b0, got_ring}, {30'b0, pte[5:4]});
      check("R7 asid", {24'b0, got_asid}, {24'b0, ring_asid[pte[5:4]*8 +: 8]});
      check("R8 ppn", got_ppn, pte & 32'hFFFF_F000);
      check("R8 attr", {28'b0, got_attr}, {28'b0, pte[3:0]});
      check("R8 vpn", got_vpn, v & 32'hFFFF_F000);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset base", base_rd_data, 32'h0);
    check("R9 reset busy", {31'b0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (base_wr_data[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [31:0] wv = 32'h9E37_79B9 * (k + 1);
      write_base(wv);
      fault_vaddr = '0;
      #1 check("R1 masked write", base_rd_data, wv & 32'hFFC0_0000);
      fault_vaddr = 32'h7654_3210 ^ (k * 32'h1111_1111);
      #1 check("R2 readback", base_rd_data,
               ((wv & 32'hFFC0_0000) | (fault_vaddr >> 10)) & 32'hFFFF_FFFC);
    end
    for (int b = 0; b < 3; b++) begin
      write_base(32'h4000_0000 * (b + 1) + 32'h0012_3456);
      for (int k = 0; k < 8; k++) begin
        logic [31:0] v = (k < 4) ? (base_model | (32'h0001_3000 * (k + 1)))
                                 : (32'h1234_5000 * k + 32'h0000_0ABC);
        do_miss(v, 2'(k), 6'(16 + k), (k % 3), 1'b0);
      end
    end
    xl_fail = 1'b1;
    do_miss(32'h0ABC_D123, 2'd2, 6'd24, 0, 1'b0);
    do_miss(32'h8765_4321, 2'd1, 6'd26, 0, 1'b0);
    xl_fail = 1'b0;
    do_miss(32'h1357_9BDF, 2'd3, 6'd18, 5, 1'b1);
    ring_asid = 32'hC3D2E1F0;
    for (int k = 0; k < 5; k++) do_miss(32'h0100_0000 * (k + 1) + 32'h2000 * k, 2'd1, 6'd2, 0, 1'b0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule